// File: doc/BRIEF.md
# Coherency State Tracker with Snoop Port

This block holds a two-bit coherency state (Modified, Exclusive, Shared, Invalid) and an address tag for every line of a small direct-mapped data cache. It updates that state from four sources: local reads, local writes, line fills and snoop inquiries. A Modified or Exclusive line is held by this cache alone. A Shared line may also sit in other caches. An Invalid line holds nothing. The encoding is Invalid=00, Shared=01, Exclusive=10, Modified=11.

Local accesses give only a line index, because the tag compare for them is done elsewhere. The block answers in the same cycle. A read of an Invalid line reports a miss. A write to a line this cache does not own outright, meaning Shared or Invalid, must also go out to main memory. Such a write neither gains ownership nor allocates the line.

Snoop inquiries arrive on their own port, alongside local traffic. Each inquiry carries the full address of a bus cycle seen from another agent and a flag that marks it as a write. The block reports a hit when the line is valid and its tag matches. It reports a separate write-back signal when the hit line is Modified. It then demotes or invalidates the line.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid: a local read of any index reports a miss, and no snoop hits.
- R2: A local read asserts `loc_miss` in the same cycle exactly when the line is Invalid; reads of Shared, Exclusive or Modified lines report no miss and leave the state unchanged.
- R3: A local write to an Exclusive line moves it to Modified with `loc_wthru` low; a write to a Modified line keeps it Modified with `loc_wthru` low.
- R4: A local write to a Shared line asserts `loc_wthru` in the same cycle, and the line stays Shared.
- R5: A local write to an Invalid line asserts `loc_wthru`, and the line stays Invalid (no allocation).
- R6: A fill writes the tag taken from the fill address. It installs the line as Exclusive when `fill_shared` is 0 and as Shared when it is 1, whatever the line held before.
- R7: `snp_hit` is asserted in the same cycle when the snoop address's index selects a non-Invalid line whose stored tag equals the address tag (tag = address bits above the index, index = bits just above the 5-bit byte offset).
- R8: A snoop write that hits moves the line to Invalid.
- R9: A snoop read that hits a Modified or Exclusive line moves it to Shared; a snoop read hit on a Shared line leaves it Shared.
- R10: `snp_hitm` is asserted in the same cycle exactly when a snoop hits a Modified line, signalling that the line must be written back.
- R11: When a snoop and a local access target the same line in one cycle, the snoop transition is applied first, and the local access's outputs and transition use the state the snoop produced.
- R12: A fill to a line overrides a snoop or local update to that same line in the same cycle; the line ends in the fill's state with the fill's tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_valid | input | 1 | Local access present this cycle |
| loc_write | input | 1 | Local access is a write (0 = read) |
| loc_idx | input | IDX_W (4) | Line index of the local access |
| loc_miss | output | 1 | Local read found the line Invalid |
| loc_wthru | output | 1 | Local write must also be written to main memory |
| fill_valid | input | 1 | Line fill completes this cycle |
| fill_addr | input | ADDR_W (32) | Address of the filled line |
| fill_shared | input | 1 | Another cache reported a copy; install as Shared |
| snp_valid | input | 1 | Snoop inquiry present this cycle |
| snp_write | input | 1 | Observed bus cycle is a write |
| snp_addr | input | ADDR_W (32) | Address of the observed bus cycle |
| snp_hit | output | 1 | Snoop address is held in a valid line |
| snp_hitm | output | 1 | Snoop hit a Modified line; write-back needed |

## Verification
The assertions assume that each port carries at most one request per cycle and that the valid and flag inputs are never X while reset is high. They also assume that the local index and the fill address refer to lines of this cache. The checks that compare the next state after a snoop or a local write exclude the case where a fill lands on the same line in that cycle, because the fill rule takes precedence there. The bench holds every valid input low between scenario steps and drives each port with a single request per cycle. It drives same-line collisions deliberately, but only in the scenarios that test the ordering rules.

// File: rtl/mesi_pkg.sv
// Shared types for the coherency state tracker.
// Assumes: two state bits per line, encoding fixed below.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_INV = 2'b00,
        ST_SHR = 2'b01,
        ST_EXC = 2'b10,
        ST_MOD = 2'b11
    } mesi_t;
endpackage

// File: rtl/mesi_snoop_eval.sv
// Snoop evaluation: decides hit / hit-on-modified for one inquiry and the
// state the inquired line moves to.
// Assumes: cur_state and tag_match describe the line the inquiry indexes.
module mesi_snoop_eval
    import mesi_pkg::*;
(
    input  logic  snp_valid,
    input  logic  snp_write,
    input  logic  tag_match,
    input  mesi_t cur_state,
    output logic  hit,
    output logic  hitm,
    output logic  upd,
    output mesi_t nxt_state
);
    // Hit detection and the demotion rule for the inquired line.
    always_comb begin
        hit       = snp_valid && tag_match && (cur_state != ST_INV);
        hitm      = hit && (cur_state == ST_MOD);
        upd       = hit;
        nxt_state = cur_state;
        if (snp_write) begin
            nxt_state = ST_INV;
        end else if (cur_state == ST_MOD || cur_state == ST_EXC) begin
            nxt_state = ST_SHR;
        end
    end
endmodule

// File: rtl/mesi_local_eval.sv
// Local access evaluation: miss and write-through decisions plus the
// silent Exclusive-to-Modified upgrade.
// Assumes: cur_state is the line state after any same-cycle snoop.
module mesi_local_eval
    import mesi_pkg::*;
(
    input  logic  loc_valid,
    input  logic  loc_write,
    input  mesi_t cur_state,
    output logic  miss,
    output logic  wthru,
    output logic  upd,
    output mesi_t nxt_state
);
    // Reads miss on Invalid; writes to non-owned lines go to memory.
    always_comb begin
        miss      = loc_valid && !loc_write && (cur_state == ST_INV);
        wthru     = loc_valid && loc_write &&
                    (cur_state == ST_SHR || cur_state == ST_INV);
        upd       = loc_valid && loc_write && (cur_state == ST_EXC);
        nxt_state = ST_MOD;
    end
endmodule

// File: rtl/mesi_line_store.sv
// Per-line state and tag registers with ordered update ports.
// Assumes: at most one update per port per cycle. When ports hit the same
// line, fill wins over local, and local wins over snoop.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int IDX_W     = 4,
    parameter int TAG_W     = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             snp_upd,
    input  logic [IDX_W-1:0] snp_idx,
    input  mesi_t            snp_nxt,
    input  logic             loc_upd,
    input  logic [IDX_W-1:0] loc_idx,
    input  mesi_t            loc_nxt,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             fill_shared,
    output mesi_t            state_q [NUM_LINES],
    output logic [TAG_W-1:0] tag_q   [NUM_LINES]
);
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
        // Register one line: reset to Invalid, then apply the highest-priority update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                state_q[g] <= ST_INV;
                tag_q[g]   <= '0;
            end else if (fill_en && fill_idx == MY_IDX) begin
                state_q[g] <= fill_shared ? ST_SHR : ST_EXC;
                tag_q[g]   <= fill_tag;
            end else if (loc_upd && loc_idx == MY_IDX) begin
                state_q[g] <= loc_nxt;
            end else if (snp_upd && snp_idx == MY_IDX) begin
                state_q[g] <= snp_nxt;
            end
        end
    end
endmodule

// File: rtl/mesi_line_ctrl.sv
// Top level: coherency state tracker for a direct-mapped cache with a
// dedicated snoop port. Splits addresses, feeds the snoop result into the
// local path (snoop first), and updates the line store.
// Assumes: byte offset of LINE_BYTES, index just above it, tag above that.
module mesi_line_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int NUM_LINES  = 16,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int IDX_W     = $clog2(NUM_LINES),
    localparam int TAG_W     = ADDR_W - OFF_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic              loc_write,
    input  logic [IDX_W-1:0]  loc_idx,
    output logic              loc_miss,
    output logic              loc_wthru,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_shared,
    input  logic              snp_valid,
    input  logic              snp_write,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_hit,
    output logic              snp_hitm
);
    logic [IDX_W-1:0] snp_idx, fill_idx;
    logic [TAG_W-1:0] snp_tag, fill_tag;
    mesi_t            state_q [NUM_LINES];
    logic [TAG_W-1:0] tag_q   [NUM_LINES];
    mesi_t            snp_cur, snp_nxt, loc_cur, loc_nxt;
    logic             snp_upd, loc_upd, tag_match;

    // Split snoop and fill addresses into index and tag fields.
    always_comb begin
        snp_idx  = snp_addr[OFF_W +: IDX_W];
        snp_tag  = snp_addr[ADDR_W-1 -: TAG_W];
        fill_idx = fill_addr[OFF_W +: IDX_W];
        fill_tag = fill_addr[ADDR_W-1 -: TAG_W];
    end

    // Look up the snooped line and compare its tag.
    always_comb begin
        snp_cur   = state_q[snp_idx];
        tag_match = (tag_q[snp_idx] == snp_tag);
    end

    mesi_snoop_eval u_snoop (
        .snp_valid (snp_valid),
        .snp_write (snp_write),
        .tag_match (tag_match),
        .cur_state (snp_cur),
        .hit       (snp_hit),
        .hitm      (snp_hitm),
        .upd       (snp_upd),
        .nxt_state (snp_nxt)
    );

    // Local view of the line: the snoop outcome comes first on a collision.
    always_comb begin
        if (snp_upd && snp_idx == loc_idx) begin
            loc_cur = snp_nxt;
        end else begin
            loc_cur = state_q[loc_idx];
        end
    end

    mesi_local_eval u_local (
        .loc_valid (loc_valid),
        .loc_write (loc_write),
        .cur_state (loc_cur),
        .miss      (loc_miss),
        .wthru     (loc_wthru),
        .upd       (loc_upd),
        .nxt_state (loc_nxt)
    );

    mesi_line_store #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W),
        .TAG_W     (TAG_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .snp_upd     (snp_upd),
        .snp_idx     (snp_idx),
        .snp_nxt     (snp_nxt),
        .loc_upd     (loc_upd),
        .loc_idx     (loc_idx),
        .loc_nxt     (loc_nxt),
        .fill_en     (fill_valid),
        .fill_idx    (fill_idx),
        .fill_tag    (fill_tag),
        .fill_shared (fill_shared),
        .state_q     (state_q),
        .tag_q       (tag_q)
    );

    AST_FILL_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        fill_valid |=> (state_q[$past(fill_idx)] ==
                        ($past(fill_shared) ? ST_SHR : ST_EXC))); // R6

    AST_SNPW_INVAL: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && snp_write && !(fill_valid && fill_idx == snp_idx))
        |=> state_q[$past(snp_idx)] == ST_INV); // R8

    AST_SNPR_SHARE: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hit && !snp_write && !(fill_valid && fill_idx == snp_idx))
        |=> state_q[$past(snp_idx)] == ST_SHR); // R9

    AST_HITM_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_hitm && !(fill_valid && fill_idx == snp_idx))
        |=> state_q[$past(snp_idx)] != ST_MOD); // R10

    AST_EXCL_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
        (loc_valid && loc_write && !loc_wthru && !(fill_valid && fill_idx == loc_idx))
        |=> state_q[$past(loc_idx)] == ST_MOD); // R3

    AST_WTHRU_NO_OWN: assert property (@(posedge clk) disable iff (!rst_n)
        loc_wthru |=> state_q[$past(loc_idx)] != ST_MOD); // R4

    AST_MISS_NOT_WTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        !(loc_miss && loc_wthru)); // R2
endmodule

// File: tb/tb_mesi_line_ctrl.sv
module tb_mesi_line_ctrl;
    localparam int ADDR_W = 32;
    localparam int IDX_W  = 4;
    localparam int NLINES = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic loc_valid = 0, loc_write = 0;
    logic [IDX_W-1:0] loc_idx = '0;
    logic fill_valid = 0, fill_shared = 0;
    logic [ADDR_W-1:0] fill_addr = '0;
    logic snp_valid = 0, snp_write = 0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic loc_miss, loc_wthru, snp_hit, snp_hitm;
    logic c_miss, c_wthru, c_hit, c_hitm;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    mesi_line_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_write(loc_write), .loc_idx(loc_idx),
        .loc_miss(loc_miss), .loc_wthru(loc_wthru),
        .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_shared(fill_shared),
        .snp_valid(snp_valid), .snp_write(snp_write), .snp_addr(snp_addr),
        .snp_hit(snp_hit), .snp_hitm(snp_hitm)
    );

    function automatic logic [ADDR_W-1:0] mk(input logic [22:0] tag, input logic [3:0] idx);
        return {tag, idx, 5'b0};
    endfunction

    task automatic chk(input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", what, act, exp);
        end
    endtask

    // One cycle of stimulus; outputs captured mid-cycle before the edge.
    task automatic apply(input logic lv, input logic lw, input logic [3:0] li,
                         input logic fv, input logic [ADDR_W-1:0] fa, input logic fs,
                         input logic sv, input logic sw, input logic [ADDR_W-1:0] sa);
        @(negedge clk);
        loc_valid = lv; loc_write = lw; loc_idx = li;
        fill_valid = fv; fill_addr = fa; fill_shared = fs;
        snp_valid = sv; snp_write = sw; snp_addr = sa;
        #1;
        c_miss = loc_miss; c_wthru = loc_wthru; c_hit = snp_hit; c_hitm = snp_hitm;
        @(posedge clk);
        #1;
        loc_valid = 0; fill_valid = 0; snp_valid = 0;
    endtask

    task automatic lrd(input logic [3:0] i);  apply(1,0,i, 0,'0,0, 0,0,'0); endtask
    task automatic lwr(input logic [3:0] i);  apply(1,1,i, 0,'0,0, 0,0,'0); endtask
    task automatic fil(input logic [ADDR_W-1:0] a, input logic s); apply(0,0,0, 1,a,s, 0,0,'0); endtask
    task automatic snp(input logic w, input logic [ADDR_W-1:0] a); apply(0,0,0, 0,'0,0, 1,w,a); endtask

    task automatic t_reset();
        for (int i = 0; i < NLINES; i++) begin
            lrd(4'(i));
            chk(c_miss, 1, "R1 reset read miss");
        end
        snp(0, mk(0, 3));
        chk(c_hit, 0, "R1 reset snoop no hit");
    endtask

    task automatic t_excl_to_mod();
        fil(mk(23'h1A, 1), 0);
        snp(0, mk(23'h1B, 1));
        chk(c_hit, 0, "R7 tag mismatch no hit");
        lrd(1);
        chk(c_miss, 0, "R2 read of exclusive no miss");
        lwr(1);
        chk(c_wthru, 0, "R3 write exclusive no wthru");
        lwr(1);
        chk(c_wthru, 0, "R3 write modified no wthru");
        snp(0, mk(23'h1A, 1));
        chk(c_hit, 1, "R7 snoop hit");
        chk(c_hitm, 1, "R10 hitm on modified");
        lwr(1);
        chk(c_wthru, 1, "R9 modified demoted to shared");
    endtask

    task automatic t_shared();
        fil(mk(23'h22, 2), 1);
        lwr(2);
        chk(c_wthru, 1, "R6 fill shared then wthru");
        lwr(2);
        chk(c_wthru, 1, "R4 shared stays shared");
        lrd(2);
        chk(c_miss, 0, "R2 read shared no miss");
        snp(0, mk(23'h22, 2));
        chk(c_hit, 1, "R9 snoop read shared hit");
        chk(c_hitm, 0, "R10 no hitm on shared");
        snp(1, mk(23'h22, 2));
        chk(c_hit, 1, "R8 snoop write hit");
        lrd(2);
        chk(c_miss, 1, "R8 line invalid after snoop write");
    endtask

    task automatic t_excl_snoop_read();
        fil(mk(23'h33, 3), 0);
        snp(0, mk(23'h33, 3));
        chk(c_hit, 1, "R9 hit exclusive");
        chk(c_hitm, 0, "R10 no hitm on exclusive");
        lwr(3);
        chk(c_wthru, 1, "R9 exclusive demoted to shared");
    endtask

    task automatic t_write_invalid();
        lwr(4);
        chk(c_wthru, 1, "R5 write invalid wthru");
        lrd(4);
        chk(c_miss, 1, "R5 no allocation");
        snp(0, mk(0, 4));
        chk(c_hit, 0, "R5 still not held");
    endtask

    task automatic t_same_cycle();
        fil(mk(23'h55, 5), 0);
        lwr(5);
        apply(1,0,5, 0,'0,0, 1,1,mk(23'h55,5));
        chk(c_hitm, 1, "R10 hitm same cycle");
        chk(c_miss, 1, "R11 local read sees snoop invalidation");
        fil(mk(23'h66, 6), 0);
        apply(1,1,6, 0,'0,0, 1,0,mk(23'h66,6));
        chk(c_wthru, 1, "R11 local write sees shared after snoop");
        snp(0, mk(23'h66, 6));
        chk(c_hitm, 0, "R11 line not upgraded after collision");
    endtask

    task automatic t_fill_priority();
        fil(mk(23'h77, 7), 0);
        lwr(7);
        apply(1,1,7, 1,mk(23'h78,7),1, 1,1,mk(23'h77,7));
        chk(c_hitm, 1, "R12 snoop saw modified before fill");
        lrd(7);
        chk(c_miss, 0, "R12 fill beats snoop invalidation");
        lwr(7);
        chk(c_wthru, 1, "R12 fill state shared");
        snp(0, mk(23'h78, 7));
        chk(c_hit, 1, "R12 fill tag stored");
        snp(0, mk(23'h77, 7));
        chk(c_hit, 0, "R6 old tag replaced");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_excl_to_mod();
        t_shared();
        t_excl_snoop_read();
        t_write_invalid();
        t_same_cycle();
        t_fill_priority();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule